// File: doc/BRIEF.md
# Logic Self-Test Controller with Signature Compaction

This block runs a built-in self-test over a piece of logic whose flops are stitched into parallel scan chains. A pseudo-random generator produces one bit per chain on every shift cycle. After the chains are full, the block issues a single system capture cycle. It then shifts the captured response out while the next pattern shifts in. Every bit that leaves the chains is folded into a multiple-input signature register.

Software or a test engine sets the pattern count, the chain length and the expected signature, then pulses `start`. When the last response has been compacted, the block raises `done`. It also raises `pass` if the signature equals the expected value. Both flags hold until the next start. The logic under test stays outside the block. Only the scan-enable, capture, scan-in and scan-out wires connect the two.

Top module: `lbist_ctrl`

## Requirements
- R1: After reset the block is idle: `done`, `pass`, `scanEn` and `captureEn` are all low.
- R2: A `start` pulse seen while idle or done loads the generator with the seed (default 8'h01) and clears `signature` to 0. It also latches `patCount`, `chainLen` and `expectSig`. A `start` seen while a test runs is ignored and does not change the result.
- R3: The generator shifts toward its MSB and inserts at bit 0 the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1). It advances only on cycles with `scanEn` high. Bit i of `scanIn` feeds chain i, and the value presented in the first shift cycle is the seed.
- R4: A test begins with a fill of `chainLen` shift cycles (a length of 0 acts as 1). During the fill, nothing is folded into the signature.
- R5: Each full load is followed by exactly one cycle with `captureEn` high and `scanEn` low. A test contains exactly `patCount` capture cycles.
- R6: After each capture, `chainLen` shift cycles unload the response and load the next pattern in the same cycles. A test therefore has `chainLen*(patCount+1)` shift cycles in all.
- R7: On each unload shift cycle the signature becomes {sig[6:0], sig[7]^sig[5]^sig[4]^sig[3]} XOR `scanOut`. The signature does not change on capture cycles or while done.
- R8: `done` rises after the last unload shift. At that point `pass` equals (signature == latched `expectSig`). Both hold, with the signature unchanged, until the next `start`. `pass` is never high while `done` is low.
- R9: With `patCount` of 0, `done` rises in the cycle after `start` with `signature` 0, and no shift or capture cycle occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test (ignored while running) |
| patCount | input | PAT_W | Number of patterns to apply |
| chainLen | input | LEN_W | Flops per scan chain |
| expectSig | input | CHAINS | Expected final signature |
| scanOut | input | CHAINS | Serial outputs of the chains, one bit each |
| scanEn | output | 1 | Shift strobe toward the chains |
| captureEn | output | 1 | System capture strobe toward the chains |
| scanIn | output | CHAINS | Generator bits, one per chain scan input |
| signature | output | CHAINS | Current signature register |
| done | output | 1 | Test finished, held until next start |
| pass | output | 1 | Signature matched the expected value |

## Verification
A generator that drifts from its sequence, or a signature register that folds on the wrong cycle, is never visible until the end. It shows only as a wrong `signature` and a low `pass` when `done` rises, as much as `chainLen*(patCount+1)+patCount` cycles after `start`. The bench therefore also follows `scanIn` on every shift cycle and counts shift and capture cycles. A sequencing fault then appears within the cycle it happens, not only in the final signature. A reference chain model checks the final signature against one computed in the bench.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_CAPT,
    S_UNLD,
    S_DONE
  } bistState_t;

  typedef struct packed {
    logic loadSeed;
    logic clearSig;
    logic latchCfg;
    logic stepGen;
    logic foldSig;
  } bistStrobe_t;

  // Feedback masks for maximal-length shift-left registers.
  function automatic logic [31:0] tapMask(int width);
    case (width)
      3:       return 32'h0006;
      4:       return 32'h000C;
      5:       return 32'h0014;
      6:       return 32'h0030;
      7:       return 32'h0060;
      8:       return 32'h00B8;
      9:       return 32'h0110;
      10:      return 32'h0240;
      11:      return 32'h0500;
      12:      return 32'h0E08;
      13:      return 32'h1C80;
      14:      return 32'h3802;
      15:      return 32'h6000;
      16:      return 32'hD008;
      default: return 32'h0000;
    endcase
  endfunction

endpackage

// File: rtl/lbist_seq.sv
module lbist_seq
  import bist_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PAT_W-1:0] patCount,
  input  logic [LEN_W-1:0] chainLen,
  output bistStrobe_t      strobe,
  output logic             scanEn,
  output logic             captureEn,
  output logic             done
);

  bistState_t       state;
  logic [LEN_W-1:0] shiftCnt;
  logic [LEN_W-1:0] lenReg;
  logic [PAT_W-1:0] patsLeft;
  logic [LEN_W:0]   nextCnt;
  logic             lastShift;
  logic             canStart;

  assign canStart  = (state == S_IDLE) || (state == S_DONE);
  assign nextCnt   = {1'b0, shiftCnt} + 1'b1;
  assign lastShift = nextCnt >= {1'b0, lenReg};

  assign scanEn    = (state == S_FILL) || (state == S_UNLD);
  assign captureEn = (state == S_CAPT);
  assign done      = (state == S_DONE);

  always_comb begin
    strobe = '0;
    if (canStart && start) begin
      strobe.loadSeed = 1'b1;
      strobe.clearSig = 1'b1;
      strobe.latchCfg = 1'b1;
    end
    if (scanEn) strobe.stepGen = 1'b1;
    if (state == S_UNLD) strobe.foldSig = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      shiftCnt <= '0;
      lenReg   <= '0;
      patsLeft <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            lenReg   <= chainLen;
            patsLeft <= patCount;
            shiftCnt <= '0;
            state    <= (patCount == '0) ? S_DONE : S_FILL;
          end
        end
        S_FILL: begin
          if (lastShift) begin
            shiftCnt <= '0;
            state    <= S_CAPT;
          end else begin
            shiftCnt <= nextCnt[LEN_W-1:0];
          end
        end
        S_CAPT: begin
          patsLeft <= patsLeft - 1'b1;
          state    <= S_UNLD;
        end
        S_UNLD: begin
          if (lastShift) begin
            shiftCnt <= '0;
            state    <= (patsLeft == '0) ? S_DONE : S_CAPT;
          end else begin
            shiftCnt <= nextCnt[LEN_W-1:0];
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lbist_dp.sv
module lbist_dp
  import bist_pkg::*;
#(
  parameter int                CHAINS = 8,
  parameter logic [CHAINS-1:0] SEED   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bistStrobe_t       strobe,
  input  logic [CHAINS-1:0] expectSig,
  input  logic [CHAINS-1:0] scanOut,
  output logic [CHAINS-1:0] scanIn,
  output logic [CHAINS-1:0] signature,
  output logic              sigMatch
);

  localparam logic [CHAINS-1:0] TAPS     = CHAINS'(tapMask(CHAINS));
  localparam logic [CHAINS-1:0] SEED_USE = (SEED == '0) ? CHAINS'(1) : SEED;

  logic [CHAINS-1:0] genReg;
  logic [CHAINS-1:0] sigReg;
  logic [CHAINS-1:0] expReg;
  logic              genFb;
  logic              sigFb;

  assign genFb = ^(genReg & TAPS);
  assign sigFb = ^(sigReg & TAPS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genReg <= SEED_USE;
    end else if (strobe.loadSeed) begin
      genReg <= SEED_USE;
    end else if (strobe.stepGen) begin
      genReg <= {genReg[CHAINS-2:0], genFb};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigReg <= '0;
    end else if (strobe.clearSig) begin
      sigReg <= '0;
    end else if (strobe.foldSig) begin
      sigReg <= {sigReg[CHAINS-2:0], sigFb} ^ scanOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReg <= '0;
    end else if (strobe.latchCfg) begin
      expReg <= expectSig;
    end
  end

  assign scanIn    = genReg;
  assign signature = sigReg;
  assign sigMatch  = (sigReg == expReg);

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import bist_pkg::*;
#(
  parameter int                CHAINS = 8,
  parameter int                LEN_W  = 8,
  parameter int                PAT_W  = 16,
  parameter logic [CHAINS-1:0] SEED   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PAT_W-1:0]  patCount,
  input  logic [LEN_W-1:0]  chainLen,
  input  logic [CHAINS-1:0] expectSig,
  input  logic [CHAINS-1:0] scanOut,
  output logic              scanEn,
  output logic              captureEn,
  output logic [CHAINS-1:0] scanIn,
  output logic [CHAINS-1:0] signature,
  output logic              done,
  output logic              pass
);

  bistStrobe_t strobe;
  logic        sigMatch;

  lbist_seq #(
    .LEN_W (LEN_W),
    .PAT_W (PAT_W)
  ) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .patCount  (patCount),
    .chainLen  (chainLen),
    .strobe    (strobe),
    .scanEn    (scanEn),
    .captureEn (captureEn),
    .done      (done)
  );

  lbist_dp #(
    .CHAINS (CHAINS),
    .SEED   (SEED)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .expectSig (expectSig),
    .scanOut   (scanOut),
    .scanIn    (scanIn),
    .signature (signature),
    .sigMatch  (sigMatch)
  );

  assign pass = done && sigMatch;

endmodule

// File: rtl/lbist_ctrl_chk.sv
module lbist_ctrl_chk #(
  parameter int CHAINS = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              scanEn,
  input logic              captureEn,
  input logic [CHAINS-1:0] scanIn,
  input logic [CHAINS-1:0] signature,
  input logic              done,
  input logic              pass
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_EXCL_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !(scanEn && captureEn)); // R5

  AST_CAPT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    captureEn |=> !captureEn); // R5

  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |-> (scanIn != '0)); // R3

  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !scanEn && !start) |=> $stable(scanIn)); // R3

  AST_SIG_NO_CAPT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && captureEn) |=> $stable(signature)); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!scanEn && !captureEn)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (armed && done && !start) |=> (done && $stable(signature) && $stable(pass))); // R8

  AST_PASS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done); // R8

endmodule

bind lbist_ctrl lbist_ctrl_chk #(.CHAINS(CHAINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .scanEn    (scanEn),
  .captureEn (captureEn),
  .scanIn    (scanIn),
  .signature (signature),
  .done      (done),
  .pass      (pass)
);

// File: tb/lbist_ctrl_bench.sv
module lbist_ctrl_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          CHAINS     = 8;
  localparam int          LEN_W      = 8;
  localparam int          PAT_W      = 16;
  localparam int          MAXL       = 16;
  localparam logic [7:0]  SEED       = 8'h01;

  typedef logic [CHAINS-1:0][MAXL-1:0] chainArr_t;

  typedef struct {
    logic [7:0] sig;
    logic       expPass;
    int         shifts;
    int         capts;
    string      tag;
  } sbItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [PAT_W-1:0]  patCount = '0;
  logic [LEN_W-1:0]  chainLen = '0;
  logic [CHAINS-1:0] expectSig = '0;
  logic [CHAINS-1:0] scanOut;
  logic              scanEn;
  logic              captureEn;
  logic [CHAINS-1:0] scanIn;
  logic [CHAINS-1:0] signature;
  logic              done;
  logic              pass;

  int        nChecks = 0;
  int        nFail = 0;
  int        curLen = 1;
  chainArr_t chainReg = '0;
  sbItem_t   sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lbist_ctrl #(
    .CHAINS (CHAINS),
    .LEN_W  (LEN_W),
    .PAT_W  (PAT_W),
    .SEED   (SEED)
  ) u_lbist_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .patCount  (patCount),
    .chainLen  (chainLen),
    .expectSig (expectSig),
    .scanOut   (scanOut),
    .scanEn    (scanEn),
    .captureEn (captureEn),
    .scanIn    (scanIn),
    .signature (signature),
    .done      (done),
    .pass      (pass)
  );

  // R3/R7 reference step: shift left, new bit 0 = b7^b5^b4^b3
  function automatic logic [7:0] step8(logic [7:0] x);
    return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
  endfunction

  function automatic chainArr_t captFn(chainArr_t c);
    chainArr_t r;
    for (int i = 0; i < CHAINS; i++)
      for (int k = 0; k < MAXL; k++)
        r[i][k] = c[i][k] ^ (c[(i+1)%CHAINS][k] & ~c[(i+2)%CHAINS][k]);
    return r;
  endfunction

  function automatic chainArr_t shiftFn(chainArr_t c, logic [CHAINS-1:0] g);
    chainArr_t r;
    for (int i = 0; i < CHAINS; i++) r[i] = {c[i][MAXL-2:0], g[i]};
    return r;
  endfunction

  // Stub of the logic under test: parallel chains plus a capture function
  always @(posedge clk) begin
    if (scanEn)         chainReg <= shiftFn(chainReg, scanIn);
    else if (captureEn) chainReg <= captFn(chainReg);
  end

  always_comb begin
    for (int i = 0; i < CHAINS; i++) scanOut[i] = chainReg[i][curLen-1];
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] modelSig(int p, int l);
    int         el = (l == 0) ? 1 : l;
    logic [7:0] gen = SEED;
    logic [7:0] sg = '0;
    logic [7:0] outv;
    chainArr_t  m = '0;
    if (p == 0) return 8'h00;
    for (int s = 0; s < el; s++) begin
      m = shiftFn(m, gen);
      gen = step8(gen);
    end
    for (int q = 0; q < p; q++) begin
      m = captFn(m);
      for (int s = 0; s < el; s++) begin
        for (int i = 0; i < CHAINS; i++) outv[i] = m[i][el-1];
        sg = step8(sg) ^ outv;
        m = shiftFn(m, gen);
        gen = step8(gen);
      end
    end
    return sg;
  endfunction

  // Driver: pushes the expected result, then launches the test
  task automatic runCase(int p, int l, bit wrongExp, bit poke, string tag);
    sbItem_t    it;
    logic [7:0] sg = modelSig(p, l);
    int         el = (l == 0) ? 1 : l;
    it.sig     = sg;
    it.expPass = !wrongExp;
    it.shifts  = (p == 0) ? 0 : el * (p + 1);
    it.capts   = p;
    it.tag     = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
    curLen    = el;
    patCount  = PAT_W'(p);
    chainLen  = LEN_W'(l);
    expectSig = wrongExp ? (sg ^ 8'h5A) : sg;
    start     = 1'b1;
    @(posedge clk); #1;
    start     = 1'b0;
    patCount  = PAT_W'(9);
    chainLen  = LEN_W'(3);
    expectSig = 8'hFF;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (sbq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R8", {tag, " done held"}, int'(done), 1);
    check(pass == it.expPass, "R8", {tag, " pass held"}, int'(pass), int'(it.expPass));
    check(signature == sg, "R8", {tag, " signature held"}, int'(signature), int'(sg));
  endtask

  // Monitor: counts strobes, follows the generator, compares at done
  initial begin
    bit         pending = 0;
    int         nShift = 0;
    int         nCapt = 0;
    int         genErr = 0;
    logic [7:0] genM = SEED;
    sbItem_t    it;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (start && !pending) begin
        pending = 1;
        nShift  = 0;
        nCapt   = 0;
        genErr  = 0;
        genM    = SEED;
      end else if (pending) begin
        if (scanEn) begin
          nShift++;
          if (scanIn != genM) genErr++;
          genM = step8(genM);
        end
        if (captureEn) nCapt++;
        if (done) begin
          pending = 0;
          it = sbq.pop_front();
          check(signature == it.sig, "R7", {it.tag, " signature"}, int'(signature), int'(it.sig));
          check(pass == it.expPass, "R8", {it.tag, " pass"}, int'(pass), int'(it.expPass));
          check(nShift == it.shifts, "R6", {it.tag, " shift cycles"}, nShift, it.shifts);
          check(nCapt == it.capts, "R5", {it.tag, " capture cycles"}, nCapt, it.capts);
          check(genErr == 0, "R3", {it.tag, " generator sequence"}, genErr, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(pass == 1'b0, "R1", "pass in reset", int'(pass), 0);
    check(scanEn == 1'b0, "R1", "scanEn in reset", int'(scanEn), 0);
    check(captureEn == 1'b0, "R1", "captureEn in reset", int'(captureEn), 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && scanEn == 1'b0, "R1", "idle after reset", int'({done, scanEn}), 0);

    runCase(1, 4, 0, 0, "R4 one pattern");
    runCase(3, 5, 0, 0, "R6 three patterns");
    runCase(6, 16, 0, 0, "R6 long chains");
    runCase(2, 0, 0, 0, "R4 zero length");
    runCase(0, 5, 0, 0, "R9 zero patterns");
    runCase(4, 7, 1, 0, "R8 wrong expect");
    runCase(3, 5, 0, 1, "R2 restart with busy start");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule